// File: doc/BRIEF.md
# Multithreaded Windowed Integer Register File

This block holds the integer registers for a group of hardware thread contexts that share one pipeline. Each context has overlapping register windows: eight globals and a ring of three 16-register windows. The block keeps each context's current window pointer and a window invalid mask. It translates a 5-bit architectural register number into a slot inside that context's private 64-slot region of one shared storage array. The trap base register of each context sits in a spare slot of the same region.

The block has two read ports and one write port. Both read ports serve the same thread in a given cycle, and a read is pipelined over two clock edges. There is no forwarding, so a read issued in the same cycle as a write to the same register returns the value before the write. A window-step input performs SAVE (pointer moves down) or RESTORE (pointer moves up), each modulo three. When the step would land on a window whose mask bit is set, the block raises a one-cycle overflow or underflow flag and leaves the pointer unchanged. Any further trap handling is left to the surrounding pipeline.

Top module: `mt_winreg_file`

## Requirements
- R1: Register 0 reads as zero on both read ports, and writes to register 0 leave every other register unchanged.
- R2: Registers 1 to 7 are the thread's globals: one storage per thread, the same value whatever the window pointer.
- R3: For register r in 8..31, with k = r - 8 and window pointer w, the storage slot is 8 + ((w*16 + k) mod 48). So r24..r31 (ins) of window w are the same storage as r8..r15 (outs) of window (w+1) mod 3, and r16..r23 (locals) belong to one window only.
- R4: Each thread has its own 64-slot region, so a write by one thread never changes a value read by another thread.
- R5: Read data and the read-valid output appear after the second rising edge that follows a cycle with rd_en high, and not after the first. Both ports deliver their data together.
- R6: If a read and a write to the same register of the same thread happen in the same cycle, the read returns the old value. A later read returns the new value.
- R7: A SAVE (win_restore=0) sets the pointer to (w+2) mod 3, so 0 goes to 2. A RESTORE (win_restore=1) sets it to (w+1) mod 3, so 2 goes to 0. The pointer of thread t is visible on cwp_all[2t+1:2t].
- R8: When a SAVE would land on window n and bit n of that thread's mask is set, win_ovf is high for exactly the cycle after the step, and the pointer is left unchanged.
- R9: When a RESTORE would land on window n and bit n of the mask is set, win_unf is high for exactly the cycle after the step, and the pointer is left unchanged.
- R10: The trap base register of each thread is stored in slot 56 of its region. It is written with wr_tbr=1, read on port A with rd_tbr_a=1, and does not change any windowed or global register.
- R11: After reset, every pointer is 0, every mask is 0, and win_ovf, win_unf and rd_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Issue a read on both ports this cycle |
| rd_tid | input | TIDW | Thread of the read |
| rd_reg_a | input | 5 | Register number, port A |
| rd_reg_b | input | 5 | Register number, port B |
| rd_tbr_a | input | 1 | Port A reads the trap base register instead |
| rd_valid | output | 1 | Read data valid, two edges after issue |
| rd_data_a | output | XLEN | Port A data |
| rd_data_b | output | XLEN | Port B data |
| wr_en | input | 1 | Write enable |
| wr_tid | input | TIDW | Thread of the write |
| wr_reg | input | 5 | Register number written |
| wr_tbr | input | 1 | Write the trap base register instead |
| wr_data | input | XLEN | Write data |
| win_en | input | 1 | Window step request |
| win_tid | input | TIDW | Thread of the window step |
| win_restore | input | 1 | 1 = RESTORE, 0 = SAVE |
| wim_we | input | 1 | Write the window invalid mask |
| wim_tid | input | TIDW | Thread whose mask is written |
| wim_data | input | NWIN | New mask, bit n guards window n |
| win_ovf | output | 1 | SAVE blocked by the mask (one-cycle pulse) |
| win_unf | output | 1 | RESTORE blocked by the mask (one-cycle pulse) |
| cwp_all | output | THREADS*CWPW | Window pointers of all threads |

## Verification
The bench fills every register of every window of every thread and then reads every register back through both ports. It also checks the wrap at slot 56 back to slot 8. A design that broke the wrap would corrupt the ins of window 2 or the globals. A design that aliased the wrong windows would show a value written as an out under a different in number. Separate cases cover a read and a write to the same register in the same cycle, where a forwarding path would return the new value too early. Other cases cover a window step blocked by the mask, where a design that still moved the pointer would then read the wrong window. Register-0 writes, isolation between threads and trap base register writes are each followed by reads of the registers they could have damaged.

// File: rtl/mt_winreg_file.sv
module mt_winreg_file #(
  parameter int THREADS = 4,
  parameter int XLEN    = 32,
  parameter int NWIN    = 3,
  parameter int TIDW    = (THREADS > 1) ? $clog2(THREADS) : 1,
  parameter int CWPW    = $clog2(NWIN)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_en,
  input  logic [TIDW-1:0]          rd_tid,
  input  logic [4:0]               rd_reg_a,
  input  logic [4:0]               rd_reg_b,
  input  logic                     rd_tbr_a,
  output logic                     rd_valid,
  output logic [XLEN-1:0]          rd_data_a,
  output logic [XLEN-1:0]          rd_data_b,
  input  logic                     wr_en,
  input  logic [TIDW-1:0]          wr_tid,
  input  logic [4:0]               wr_reg,
  input  logic                     wr_tbr,
  input  logic [XLEN-1:0]          wr_data,
  input  logic                     win_en,
  input  logic [TIDW-1:0]          win_tid,
  input  logic                     win_restore,
  input  logic                     wim_we,
  input  logic [TIDW-1:0]          wim_tid,
  input  logic [NWIN-1:0]          wim_data,
  output logic                     win_ovf,
  output logic                     win_unf,
  output logic [THREADS*CWPW-1:0]  cwp_all
);

  localparam int REGION   = 64;
  localparam int WIN_SPAN = NWIN * 16;
  localparam int TBR_SLOT = 8 + WIN_SPAN;
  localparam int DEPTH    = THREADS * REGION;
  localparam int AW       = TIDW + 6;

  logic [XLEN-1:0] regs_q [DEPTH];
  logic [CWPW-1:0] cwp_q  [THREADS];
  logic [NWIN-1:0] wim_q  [THREADS];

  function automatic logic [5:0] slot_of(input logic [CWPW-1:0] w, input logic [4:0] r);
    logic [6:0] lin;
    lin = 7'(w) * 7'd16 + 7'(r - 5'd8);
    if (lin >= 7'(WIN_SPAN)) lin = lin - 7'(WIN_SPAN);
    if (r < 5'd8) return {1'b0, r};
    return 6'(lin + 7'd8);
  endfunction

  logic [AW-1:0] rd_addr_a, rd_addr_b, wr_addr;
  assign rd_addr_a = {rd_tid, rd_tbr_a ? 6'(TBR_SLOT) : slot_of(cwp_q[rd_tid], rd_reg_a)};
  assign rd_addr_b = {rd_tid, slot_of(cwp_q[rd_tid], rd_reg_b)};
  assign wr_addr   = {wr_tid, wr_tbr ? 6'(TBR_SLOT) : slot_of(cwp_q[wr_tid], wr_reg)};

  always_ff @(posedge clk)
    if (wr_en && (wr_tbr || wr_reg != 5'd0)) regs_q[wr_addr] <= wr_data;

  logic [XLEN-1:0] raw_a_q, raw_b_q;
  logic            zero_a_q, zero_b_q, v1_q;

  always_ff @(posedge clk) begin
    raw_a_q   <= regs_q[rd_addr_a];
    raw_b_q   <= regs_q[rd_addr_b];
    zero_a_q  <= (rd_reg_a == 5'd0) && !rd_tbr_a;
    zero_b_q  <= (rd_reg_b == 5'd0);
    rd_data_a <= zero_a_q ? '0 : raw_a_q;
    rd_data_b <= zero_b_q ? '0 : raw_b_q;
  end

  always_ff @(posedge clk)
    if (!rst_n) begin
      v1_q     <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      v1_q     <= rd_en;
      rd_valid <= v1_q;
    end

  logic [CWPW-1:0] w_cur, w_new;
  logic            blocked;
  assign w_cur   = cwp_q[win_tid];
  assign w_new   = win_restore ? ((w_cur == CWPW'(NWIN-1)) ? '0 : w_cur + 1'b1)
                               : ((w_cur == '0) ? CWPW'(NWIN-1) : w_cur - 1'b1);
  assign blocked = wim_q[win_tid][w_new];

  always_ff @(posedge clk)
    if (!rst_n) begin
      for (int t = 0; t < THREADS; t++) begin
        cwp_q[t] <= '0;
        wim_q[t] <= '0;
      end
      win_ovf <= 1'b0;
      win_unf <= 1'b0;
    end else begin
      win_ovf <= win_en && blocked && !win_restore;
      win_unf <= win_en && blocked &&  win_restore;
      if (wim_we) wim_q[wim_tid] <= wim_data;
      if (win_en && !blocked) cwp_q[win_tid] <= w_new;
    end

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    assign cwp_all[t*CWPW +: CWPW] = cwp_q[t];

    assert_cwp_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cwp_q[t] < CWPW'(NWIN));

    assert_trap_keeps_cwp_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (win_en && win_tid == TIDW'(t) && blocked) |=> (cwp_q[t] == $past(cwp_q[t])));
  end

  assert_r0_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_reg_b == 5'd0) |=> ##1 (rd_data_b == '0));

  assert_read_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> ##1 rd_valid);

  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(win_ovf && win_unf));

  assert_ovf_needs_save_R8: assert property (@(posedge clk) disable iff (!rst_n)
    win_ovf |-> $past(win_en && !win_restore));

  assert_unf_needs_restore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    win_unf |-> $past(win_en && win_restore));

endmodule

// File: tb/sim_mt_winreg_file.sv
module sim_mt_winreg_file;
  localparam int TH = 4;

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic rd_en = 0, rd_tbr_a = 0, wr_en = 0, wr_tbr = 0, win_en = 0, win_restore = 0, wim_we = 0;
  logic [1:0] rd_tid = 0, wr_tid = 0, win_tid = 0, wim_tid = 0;
  logic [4:0] rd_reg_a = 0, rd_reg_b = 0, wr_reg = 0;
  logic [31:0] wr_data = 0, rd_data_a, rd_data_b;
  logic [2:0] wim_data = 0;
  logic rd_valid, win_ovf, win_unf;
  logic [7:0] cwp_all;

  mt_winreg_file u0 (.*);

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] model [TH][64];
  int mcwp [TH];
  logic [2:0] mwim [TH];

  function automatic int slot(int w, int r);
    if (r < 8) return r;
    return 8 + (w * 16 + r - 8) % 48;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int t, int r, logic [31:0] v, bit tbr = 0);
    wr_en = 1; wr_tid = 2'(t); wr_reg = 5'(r); wr_data = v; wr_tbr = tbr;
    @(negedge clk);
    wr_en = 0; wr_tbr = 0;
    if (tbr) model[t][56] = v;
    else if (r != 0) model[t][slot(mcwp[t], r)] = v;
  endtask

  function automatic string tag_of(int r);
    if (r == 0) return "R1";
    if (r < 8) return "R2";
    return "R3";
  endfunction

  task automatic rd(int t, int ra, int rb, bit tbr = 0, string req = "");
    logic [31:0] ea, eb;
    ea = tbr ? model[t][56] : (ra == 0 ? 32'h0 : model[t][slot(mcwp[t], ra)]);
    eb = (rb == 0) ? 32'h0 : model[t][slot(mcwp[t], rb)];
    rd_en = 1; rd_tid = 2'(t); rd_reg_a = 5'(ra); rd_reg_b = 5'(rb); rd_tbr_a = tbr;
    @(negedge clk);
    rd_en = 0; rd_tbr_a = 0;
    chk("R5 valid early", {31'b0, rd_valid}, 32'h0);
    @(negedge clk);
    chk("R5 valid", {31'b0, rd_valid}, 32'h1);
    chk(req == "" ? (tbr ? "R10" : tag_of(ra)) : req, rd_data_a, ea);
    chk(req == "" ? tag_of(rb) : req, rd_data_b, eb);
  endtask

  task automatic step(int t, bit restore);
    int nw;
    bit blk;
    nw = restore ? (mcwp[t] + 1) % 3 : (mcwp[t] + 2) % 3;
    blk = mwim[t][nw];
    win_en = 1; win_tid = 2'(t); win_restore = restore;
    @(negedge clk);
    win_en = 0;
    if (!blk) mcwp[t] = nw;
    chk("R8 ovf", {31'b0, win_ovf}, {31'b0, blk && !restore});
    chk("R9 unf", {31'b0, win_unf}, {31'b0, blk && restore});
    chk("R7 cwp", {30'b0, cwp_all[t*2 +: 2]}, 32'(mcwp[t]));
  endtask

  task automatic setwim(int t, logic [2:0] m);
    wim_we = 1; wim_tid = 2'(t); wim_data = m;
    @(negedge clk);
    wim_we = 0; mwim[t] = m;
  endtask

  initial begin
    for (int t = 0; t < TH; t++) begin mcwp[t] = 0; mwim[t] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11 cwp", {24'b0, cwp_all}, 32'h0);
    chk("R11 flags", {30'b0, win_ovf, win_unf}, 32'h0);
    chk("R11 valid", {31'b0, rd_valid}, 32'h0);

    // fill every window of every thread
    for (int t = 0; t < TH; t++)
      for (int w = 0; w < 3; w++) begin
        if (w != 0) step(t, 1);
        for (int r = 0; r < 32; r++)
          wr(t, r, {8'(t), 8'(w), 8'(r), 8'hA5});
      end

    // read back everything: R1, R2, R3, R4
    for (int t = 0; t < TH; t++)
      for (int w = 0; w < 3; w++) begin
        step(t, 1);
        for (int r = 0; r < 32; r++) rd(t, r, 31 - r);
      end

    // R3 explicit alias: out of window w is in of window w-1 after SAVE
    wr(0, 9, 32'hCAFE_0009);
    step(0, 0);
    rd(0, 25, 17, 0, "R3 alias");

    // R1 write to r0 discarded, neighbours intact
    wr(1, 0, 32'hFFFF_FFFF);
    rd(1, 0, 1, 0, "R1 r0 write");
    rd(1, 8, 31, 0, "R1 r0 write");

    // R2 globals same in every window
    wr(2, 5, 32'h6105_0005);
    for (int k = 0; k < 3; k++) begin
      step(2, 0);
      rd(2, 5, 7, 0, "R2 global");
    end

    // R4 isolation
    wr(2, 17, 32'h0000_2217);
    rd(3, 17, 5, 0, "R4 isolation");
    rd(2, 17, 5, 0, "R4 isolation");

    // R10 trap base register
    for (int t = 0; t < TH; t++) wr(t, 0, 32'hB000_0000 + t, 1);
    for (int t = 0; t < TH; t++) rd(t, 0, 24, 1, "R10 tbr");
    rd(3, 31, 8, 0, "R10 regs intact");

    // R6 same-cycle read and write
    rd_en = 1; rd_tid = 2'd1; rd_reg_a = 5'd20; rd_reg_b = 5'd3;
    wr_en = 1; wr_tid = 2'd1; wr_reg = 5'd20; wr_data = 32'h0BAD_F00D;
    begin
      logic [31:0] old_a, old_b;
      old_a = model[1][slot(mcwp[1], 20)];
      old_b = model[1][3];
      @(negedge clk);
      rd_en = 0; wr_en = 0;
      model[1][slot(mcwp[1], 20)] = 32'h0BAD_F00D;
      @(negedge clk);
      chk("R6 old value", rd_data_a, old_a);
      chk("R6 other port", rd_data_b, old_b);
    end
    rd(1, 20, 3, 0, "R6 new value");

    // R8 overflow: SAVE onto masked window
    setwim(0, 3'(1 << ((mcwp[0] + 2) % 3)));
    step(0, 0);
    rd(0, 16, 30, 0, "R8 window kept");
    // R9 underflow: RESTORE onto masked window
    setwim(0, 3'(1 << ((mcwp[0] + 1) % 3)));
    step(0, 1);
    rd(0, 16, 30, 0, "R9 window kept");
    // mask cleared: steps proceed, wrap both ways (R7)
    setwim(0, 3'b000);
    while (mcwp[0] != 0) step(0, 1);
    step(0, 0);
    chk("R7 save wrap", {30'b0, cwp_all[1:0]}, 32'd2);
    step(0, 1);
    chk("R7 restore wrap", {30'b0, cwp_all[1:0]}, 32'd0);
    // other thread's mask does not block
    setwim(1, 3'b111);
    step(0, 0);
    chk("R8 per thread mask", {31'b0, win_ovf}, 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule